// File: doc/BRIEF.md
# Seven-Operand Carry-Save Adder Tree

This block adds seven unsigned operands of `W` bits each in one pass. Four levels of carry-save rows bring the seven operands down to two vectors. Each row is a set of independent full adders. Every full adder takes three bits of one weight and returns a sum bit of that weight and a carry bit one place higher. The carry vector of each row is shifted left by one place before the next row uses it. After the fourth level, a single ripple carry-propagate adder turns the remaining pair into the `W+3`-bit total. That width holds the largest possible total, 7·(2^W − 1), without loss.

The reduction order is fixed. Level one compresses operands 0–2 and operands 3–5. Level two compresses both vectors from the first row with the sum vector of the second row. Level three adds the carry vector left over from the second row. Level four adds operand 6. The operands are packed on `op_flat`: operand j sits at bits `[j*W +: W]`.

The output stage is chosen by the parameter `REG_OUT`. When `REG_OUT` is 1 (the default), it is a two-state machine:
- `ST_EMPTY` means no result was captured on the last edge.
- `ST_FULL` means a result was captured.
- Transition `ST_EMPTY→ST_FULL` and transition `ST_FULL→ST_FULL` happen on an edge with `in_valid` high.
- Transition `ST_FULL→ST_EMPTY` and transition `ST_EMPTY→ST_EMPTY` happen on an edge with `in_valid` low.

The total register loads only when `in_valid` is high. When `REG_OUT` is 0, the stage is a plain wire and there is no latency.

Top module: `csa7_tree`

## Requirements
- R1: After reset, with `REG_OUT`=1, `out_valid` is 0 and `sum_out` is 0.
- R2: With `REG_OUT`=1, if `in_valid` is high at a rising edge, then after that edge `sum_out` equals the exact sum of the seven operands, operand j being `op_flat[j*W +: W]`.
- R3: With `REG_OUT`=1, after each rising edge `out_valid` equals the `in_valid` sampled at that edge. The state is `ST_FULL` when it is 1 and `ST_EMPTY` when it is 0.
- R4: An edge with `in_valid` low leaves `sum_out` unchanged, whatever values are on `op_flat`.
- R5: The total never wraps. All operands at 2^W − 1 give 7·(2^W − 1) on the `W+3`-bit output.
- R6: Seven zero operands give a total of 0.
- R7: The total does not depend on which operand lane a value uses. Any permutation of the same seven values gives the same total.
- R8: A value placed in any single lane, with the other six lanes zero, appears unchanged on `sum_out`.
- R9: With `in_valid` held high on consecutive edges, a new correct total appears after every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands on `op_flat` are valid this cycle |
| op_flat | input | 7*W | Seven packed operands, operand j at `[j*W +: W]` |
| out_valid | output | 1 | `sum_out` holds a fresh total |
| sum_out | output | W+3 | Sum of the seven operands |

## Verification
The bench places one nonzero value in each lane by turn. A wrongly wired or wrongly shifted lane would then lose the value or scale it. Operands that are all ones push the carry into the top output bit. A tree that dropped a carry bit or truncated to fewer than `W+3` bits would return a wrapped total. Cycles with `in_valid` low carry fresh, different operands. A register that loads without a qualifier would change the held total and raise `out_valid`. Long back-to-back random runs with a fixed seed expose a result that comes out one cycle late or is mixed with the previous vector.

// File: rtl/csa7_pkg.sv
package csa7_pkg;

    // Number of operands the tree reduces.
    localparam int unsigned NUM_OPS = 7;

    // Growth in width needed to hold 7 * (2^W - 1).
    localparam int unsigned GROW = 3;

    // State of the output capture stage.
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/csa_fa.sv
// One full-adder cell: three bits of equal weight in, sum and carry out.
module csa_fa (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic co_o
);

    logic ab_x;

    always_comb begin
        ab_x = a_i ^ b_i;
        s_o  = ab_x ^ c_i;
        co_o = (a_i & b_i) | (ab_x & c_i);
    end

endmodule

// File: rtl/csa_row.sv
// One carry-save row: OW independent full adders. The carry vector is
// returned already aligned to its weight (shifted up one place). The top
// carry is dropped because the caller guarantees the value fits in OW bits.
module csa_row #(
    parameter int unsigned OW = 11
) (
    input  logic [OW-1:0] x_i,
    input  logic [OW-1:0] y_i,
    input  logic [OW-1:0] z_i,
    output logic [OW-1:0] sum_o,
    output logic [OW-1:0] cry_o
);

    logic [OW-1:0] raw_cry;

    for (genvar b = 0; b < OW; b++) begin : g_cell
        csa_fa u_fa (
            .a_i  (x_i[b]),
            .b_i  (y_i[b]),
            .c_i  (z_i[b]),
            .s_o  (sum_o[b]),
            .co_o (raw_cry[b])
        );
    end

    always_comb begin
        cry_o = {raw_cry[OW-2:0], 1'b0};
    end

endmodule

// File: rtl/csa_cpa.sv
// Final carry-propagate adder: a ripple chain of full-adder cells.
module csa_cpa #(
    parameter int unsigned OW = 11
) (
    input  logic [OW-1:0] p_i,
    input  logic [OW-1:0] q_i,
    output logic [OW-1:0] tot_o
);

    logic [OW:0] chain;

    assign chain[0] = 1'b0;

    for (genvar b = 0; b < OW; b++) begin : g_rip
        csa_fa u_fa (
            .a_i  (p_i[b]),
            .b_i  (q_i[b]),
            .c_i  (chain[b]),
            .s_o  (tot_o[b]),
            .co_o (chain[b+1])
        );
    end

    // The carry out of the top bit is always zero by range; it is left unused.
    logic unused_top;
    assign unused_top = chain[OW];

endmodule

// File: rtl/csa_out_stage.sv
// Output stage: a two-state capture machine, or a wire if REG_OUT is 0.
module csa_out_stage
    import csa7_pkg::*;
#(
    parameter int unsigned OW      = 11,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          v_i,
    input  logic [OW-1:0] d_i,
    output logic          v_o,
    output logic [OW-1:0] d_o
);

    if (REG_OUT) begin : g_reg
        out_state_e    st_q;
        logic [OW-1:0] hold_q;

        // State register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= ST_EMPTY;
            end else begin
                unique case (st_q)
                    ST_EMPTY: st_q <= v_i ? ST_FULL : ST_EMPTY;
                    ST_FULL:  st_q <= v_i ? ST_FULL : ST_EMPTY;
                endcase
            end
        end

        // Data register, loaded only on a valid edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_q <= '0;
            end else if (v_i) begin
                hold_q <= d_i;
            end
        end

        // Outputs
        always_comb begin
            unique case (st_q)
                ST_EMPTY: v_o = 1'b0;
                ST_FULL:  v_o = 1'b1;
            endcase
            d_o = hold_q;
        end
    end else begin : g_wire
        assign v_o = v_i;
        assign d_o = d_i;
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
    end

endmodule

// File: rtl/csa7_tree.sv
// Seven-operand carry-save adder tree with one final carry-propagate adder.
module csa7_tree
    import csa7_pkg::*;
#(
    parameter int unsigned W       = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [NUM_OPS*W-1:0]    op_flat,
    output logic                    out_valid,
    output logic [W+GROW-1:0]       sum_out
);

    localparam int unsigned OW = W + GROW;

    // Operands zero-extended to the output width
    logic [OW-1:0] opx [NUM_OPS];

    for (genvar j = 0; j < NUM_OPS; j++) begin : g_unpack
        assign opx[j] = {{GROW{1'b0}}, op_flat[j*W +: W]};
    end

    // Level 1: two rows
    logic [OW-1:0] s1a, c1a, s1b, c1b;

    csa_row #(.OW(OW)) u_l1a (
        .x_i(opx[0]), .y_i(opx[1]), .z_i(opx[2]),
        .sum_o(s1a), .cry_o(c1a)
    );

    csa_row #(.OW(OW)) u_l1b (
        .x_i(opx[3]), .y_i(opx[4]), .z_i(opx[5]),
        .sum_o(s1b), .cry_o(c1b)
    );

    // Level 2
    logic [OW-1:0] s2, c2;

    csa_row #(.OW(OW)) u_l2 (
        .x_i(s1a), .y_i(c1a), .z_i(s1b),
        .sum_o(s2), .cry_o(c2)
    );

    // Level 3
    logic [OW-1:0] s3, c3;

    csa_row #(.OW(OW)) u_l3 (
        .x_i(s2), .y_i(c2), .z_i(c1b),
        .sum_o(s3), .cry_o(c3)
    );

    // Level 4
    logic [OW-1:0] s4, c4;

    csa_row #(.OW(OW)) u_l4 (
        .x_i(s3), .y_i(c3), .z_i(opx[6]),
        .sum_o(s4), .cry_o(c4)
    );

    // Single carry-propagate addition
    logic [OW-1:0] total;

    csa_cpa #(.OW(OW)) u_cpa (
        .p_i(s4), .q_i(c4), .tot_o(total)
    );

    csa_out_stage #(.OW(OW), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (in_valid),
        .d_i   (total),
        .v_o   (out_valid),
        .d_o   (sum_out)
    );

endmodule

// File: rtl/csa7_tree_chk.sv
// Checker bound to the top module.
module csa7_tree_chk
    import csa7_pkg::*;
#(
    parameter int unsigned W       = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [NUM_OPS*W-1:0] op_flat,
    input logic                 out_valid,
    input logic [W+GROW-1:0]    sum_out
);

    localparam int unsigned OW = W + GROW;
    localparam logic [OW-1:0] MAX_TOT = OW'(NUM_OPS) * OW'((1 << W) - 1);

    logic [OW-1:0] ref_now;

    always_comb begin
        ref_now = '0;
        for (int j = 0; j < NUM_OPS; j++) begin
            ref_now = ref_now + OW'(op_flat[j*W +: W]);
        end
    end

    if (REG_OUT) begin : g_reg_chk
        AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (sum_out == $past(ref_now)));                // R2
        AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);                                  // R3
        AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);                                // R3
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(sum_out));                          // R4
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sum_out <= MAX_TOT);                                          // R5

endmodule

bind csa7_tree csa7_tree_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_flat(op_flat),
    .out_valid(out_valid), .sum_out(sum_out)
);

// File: tb/csa7_tree_tb.sv
`timescale 1ns/1ps
module csa7_tree_tb;

    localparam int W  = 8;
    localparam int N  = 7;
    localparam int OW = W + 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [N*W-1:0]  op_flat = '0;
    logic            out_valid;
    logic [OW-1:0]   sum_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    csa7_tree #(.W(W), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_flat(op_flat),
        .out_valid(out_valid), .sum_out(sum_out)
    );

    function automatic logic [OW-1:0] model_sum(input logic [N*W-1:0] v);
        logic [OW-1:0] acc = '0;
        for (int j = 0; j < N; j++) acc = acc + OW'(v[j*W +: W]);
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one vector at a falling edge, then sample at the next falling edge.
    task automatic step(input logic v, input logic [N*W-1:0] ops);
        @(negedge clk);
        in_valid = v;
        op_flat  = ops;
        @(negedge clk);
    endtask

    task automatic check_result(input logic [N*W-1:0] ops, input string req);
        step(1'b1, ops);
        check(sum_out == model_sum(ops), req, int'(sum_out), int'(model_sum(ops)));
        check(out_valid == 1'b1, "R3", int'(out_valid), 1);
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] v, perm, held;
        logic [OW-1:0]  kept;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(sum_out == '0, "R1", int'(sum_out), 0);
        rst_n = 1'b1;

        // R6: all zero
        check_result('0, "R6");

        // R5: all ones, 7*255 = 1785
        v = '1;
        step(1'b1, v);
        check(sum_out == OW'(1785), "R5", int'(sum_out), 1785);

        // R8: single nonzero lane
        for (int j = 0; j < N; j++) begin
            v = '0;
            v[j*W +: W] = 8'hA5;
            step(1'b1, v);
            check(sum_out == OW'(8'hA5), "R8", int'(sum_out), 165);
        end

        // R7: permutation gives the same total
        for (int j = 0; j < N; j++) v[j*W +: W] = W'(10 + 31*j);
        for (int j = 0; j < N; j++) perm[j*W +: W] = v[(N-1-j)*W +: W];
        step(1'b1, v);
        kept = sum_out;
        step(1'b1, perm);
        check(sum_out == kept, "R7", int'(sum_out), int'(kept));
        check(sum_out == model_sum(v), "R7", int'(sum_out), int'(model_sum(v)));

        // R4 / R3: idle edges with new operands leave the total unchanged
        kept = sum_out;
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < N; j++) held[j*W +: W] = W'($urandom);
            step(1'b0, held);
            check(sum_out == kept, "R4", int'(sum_out), int'(kept));
            check(out_valid == 1'b0, "R3", int'(out_valid), 0);
        end

        // R2 / R9: back-to-back random vectors, one result per edge
        @(negedge clk);
        for (int k = 0; k < 300; k++) begin
            for (int j = 0; j < N; j++) v[j*W +: W] = W'($urandom);
            if (k % 37 == 5) v = '1;
            in_valid = 1'b1;
            op_flat  = v;
            @(negedge clk);
            check(sum_out == model_sum(v), (k % 2) ? "R9" : "R2",
                  int'(sum_out), int'(model_sum(v)));
            check(out_valid == 1'b1, "R9", int'(out_valid), 1);
        end
        in_valid = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule